// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

The block watches one timer input pin, already brought into the clock domain by a two-flop stage upstream. On qualifying transitions it copies the running counter into one of two capture slots. The first qualifying transition fills slot 1 and the second fills slot 2. After that the unit is locked, and it ignores edges until software restarts it. A single-cycle event strobe goes to the interrupt logic. A mode bit chooses whether that strobe marks the first capture or the second, so software can wait for a full period or pulse-width measurement before it is interrupted.

The edge selection, the pin direction and the count mode are live control fields. A write strobe from the control register tells the unit when a new edge selection is being written, so that it can spot a change from "off" to an active setting. Software restarts the capture sequence by writing 1 to the capture bit of the interrupt status register, which reaches the unit as a one-cycle clear strobe. The unit also raises a combinational flag whenever an edge selection is active while the pin is configured as an output.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both capture slots read 0 and the event strobe is low.
- R2: The edge selection field is encoded as 2'b00 off, 2'b01 rising (0 to 1), 2'b10 falling (1 to 0) and 2'b11 any transition. An edge is the synchronised pin differing from its value one clock earlier, with the earlier value starting at 0 after reset.
- R3: No capture is taken while `pin_is_input_i` is 0, whatever the pin does.
- R4: The first qualifying edge stores `count_i` of the edge cycle into slot 1, and the second stores it into slot 2. Either value is visible one clock later. Further edges change neither slot until the capture sequence is restarted.
- R5: `cap_evt_o` pulses high for exactly one cycle, together with the slot 1 update when `second_sel_i` is 0, or together with the slot 2 update when it is 1.
- R6: A `cap_clr_i` pulse restarts the sequence. If it falls in the same cycle as a qualifying edge, that edge is taken as capture 1.
- R7: A `ctl_wr_i` pulse restarts the sequence when the previously written edge selection is 2'b00 and the new one is not 2'b00. A write from one active selection to another leaves the sequence as it was. The stored selection is 2'b00 after reset.
- R8: `misconfig_o` is 1 exactly when `edge_mode_i` is not 2'b00 and `pin_is_input_i` is 0, in the same cycle.
- R9: The slots are changed only by captures. A restart leaves their contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sync_i | input | 1 | Synchronised timer input pin |
| count_i | input | CNT_W | Live counter value |
| edge_mode_i | input | 2 | Edge selection field |
| second_sel_i | input | 1 | 0: event on first capture, 1: on second |
| pin_is_input_i | input | 1 | Pin direction, 1 selects input |
| ctl_wr_i | input | 1 | Control register write strobe |
| cap_clr_i | input | 1 | Write-1 to capture status bit strobe |
| cap1_o | output | CNT_W | Capture slot 1 |
| cap2_o | output | CNT_W | Capture slot 2 |
| cap_evt_o | output | 1 | Capture event strobe |
| misconfig_o | output | 1 | Active edge selection on an output pin |

## Verification
The hardest situations to reach are the restart races. One is a clear strobe landing in the same cycle as an edge while the unit is locked. The other is a control write passing through the "off" selection, or skipping it. The bench runs every edge selection under both count modes and both pin directions. Each run passes through "off", clears, plays a fixed pin pattern that locks the unit, and finishes with a clear coinciding with a transition. A bench-side model predicts every slot and the strobe cycle by cycle, and directed sequences add the active-to-active control writes.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned SEQ_W     = $clog2(NUM_SLOTS + 1);

  function automatic logic edge_match(input edge_sel_e sel,
                                      input logic prev,
                                      input logic cur);
    logic hit;
    unique case (sel)
      EDGE_RISE: hit = !prev && cur;
      EDGE_FALL: hit = prev && !cur;
      EDGE_ANY:  hit = prev != cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ecap_edge_detect.sv
module ecap_edge_detect
  import ecap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);

  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  always_comb begin
    hit_o = edge_match(sel_i, pin_q, pin_i);
  end

  // R2: an edge always means the pin moved since the previous cycle
  a_r2_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (pin_i != pin_q));

endmodule

// File: rtl/ecap_seq_ctrl.sv
module ecap_seq_ctrl
  import ecap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_i,
  input  logic                 dir_in_i,
  input  logic                 second_sel_i,
  input  logic                 clr_i,
  input  logic                 ctl_wr_i,
  input  edge_sel_e            sel_new_i,
  output logic [NUM_SLOTS-1:0] slot_we_o,
  output logic                 evt_o,
  output logic                 full_o
);

  logic [SEQ_W-1:0] seq_q, seq_d, seq_base;
  edge_sel_e        sel_q, sel_d;
  logic             evt_q, evt_d;
  logic             restart;
  logic             take;

  always_comb begin
    restart  = clr_i || (ctl_wr_i && (sel_q == EDGE_OFF) && (sel_new_i != EDGE_OFF));
    seq_base = restart ? '0 : seq_q;
    take     = hit_i && dir_in_i && (seq_base != SEQ_W'(NUM_SLOTS));
    seq_d    = take ? seq_base + 1'b1 : seq_base;
    evt_d    = take && (seq_base == SEQ_W'(second_sel_i));
    sel_d    = ctl_wr_i ? sel_new_i : sel_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_we_o[i] = take && (seq_base == SEQ_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      sel_q <= EDGE_OFF;
      evt_q <= 1'b0;
    end else begin
      seq_q <= seq_d;
      sel_q <= sel_d;
      evt_q <= evt_d;
    end
  end

  assign evt_o  = evt_q;
  assign full_o = (seq_q == SEQ_W'(NUM_SLOTS));

  // R5 / R6: a clear alongside an edge in first-capture mode yields an event
  a_r5_clr_edge_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && dir_in_i && !second_sel_i && clr_i) |=> evt_o);

  // R4: sequence position never passes the number of slots
  a_r4_seq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q <= SEQ_W'(NUM_SLOTS));

endmodule

// File: rtl/ecap_slot_bank.sv
module ecap_slot_bank
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            we_i,
  input  logic [CNT_W-1:0]                count_i,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_o
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [CNT_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (we_i[g]) val_q <= count_i;
    end
    assign slot_o[g] = val_q;
  end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_sync_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             second_sel_i,
  input  logic             pin_is_input_i,
  input  logic             ctl_wr_i,
  input  logic             cap_clr_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             cap_evt_o,
  output logic             misconfig_o
);

  logic                            rst_meta_q, rst_sync_n;
  edge_sel_e                       sel;
  logic                            hit;
  logic [NUM_SLOTS-1:0]            slot_we;
  logic                            full;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign sel = edge_sel_e'(edge_mode_i);

  ecap_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_i (pin_sync_i),
    .sel_i (sel),
    .hit_o (hit)
  );

  ecap_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .hit_i        (hit),
    .dir_in_i     (pin_is_input_i),
    .second_sel_i (second_sel_i),
    .clr_i        (cap_clr_i),
    .ctl_wr_i     (ctl_wr_i),
    .sel_new_i    (sel),
    .slot_we_o    (slot_we),
    .evt_o        (cap_evt_o),
    .full_o       (full)
  );

  ecap_slot_bank #(.CNT_W(CNT_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (slot_we),
    .count_i (count_i),
    .slot_o  (slots)
  );

  assign cap1_o      = slots[0];
  assign cap2_o      = slots[1];
  assign misconfig_o = (sel != EDGE_OFF) && !pin_is_input_i;

  // R3: an output-configured pin never changes the slots
  a_r3_no_capture_output: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pin_is_input_i |=> ($stable(cap1_o) && $stable(cap2_o)));

  // R4: once locked, slots hold unless a restart arrives
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (full && !cap_clr_i && !ctl_wr_i) |=> ($stable(cap1_o) && $stable(cap2_o)));

  // R6: clear together with an edge captures into slot 1
  a_r6_clr_edge_slot1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_clr_i && hit && pin_is_input_i) |=> (cap1_o == $past(count_i)));

  // R9: without an edge the slots keep their contents
  a_r9_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> ($stable(cap1_o) && $stable(cap2_o)));

endmodule

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pin_sync_i;
  logic [W-1:0] count_i;
  logic [1:0]   edge_mode_i;
  logic         second_sel_i;
  logic         pin_is_input_i;
  logic         ctl_wr_i;
  logic         cap_clr_i;
  logic [W-1:0] cap1_o, cap2_o;
  logic         cap_evt_o, misconfig_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic         m_pin;
  int           m_seq;
  logic [W-1:0] m_cap1, m_cap2;
  logic         m_evt;
  logic [1:0]   m_mode;
  logic         cur_pin;

  always #4 clk = ~clk;

  edge_capture_unit #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pin_sync_i(pin_sync_i), .count_i(count_i),
    .edge_mode_i(edge_mode_i), .second_sel_i(second_sel_i),
    .pin_is_input_i(pin_is_input_i), .ctl_wr_i(ctl_wr_i), .cap_clr_i(cap_clr_i),
    .cap1_o(cap1_o), .cap2_o(cap2_o), .cap_evt_o(cap_evt_o), .misconfig_o(misconfig_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit qualifies(input logic [1:0] md, input logic p, input logic c);
    case (md)
      2'b01:   return !p && c;
      2'b10:   return p && !c;
      2'b11:   return p != c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic pin, input logic clr, input logic wr,
                      input logic [1:0] mode, input string tag);
    logic [W-1:0] cnt;
    int base;
    bit mrst;
    @(negedge clk);
    check(cap1_o == m_cap1, tag, "slot1", cap1_o, m_cap1);
    check(cap2_o == m_cap2, tag, "slot2", cap2_o, m_cap2);
    check(cap_evt_o == m_evt, {tag, " R5"}, "event", W'(cap_evt_o), W'(m_evt));
    cyc++;
    cnt            = 32'h1000_0000 + 32'(cyc * 13);
    pin_sync_i     = pin;
    cap_clr_i      = clr;
    ctl_wr_i       = wr;
    edge_mode_i    = mode;
    count_i        = cnt;
    #1;
    check(misconfig_o == ((mode != 2'b00) && !pin_is_input_i), "R8", "misconfig",
          W'(misconfig_o), W'((mode != 2'b00) && !pin_is_input_i));
    mrst  = wr && (m_mode == 2'b00) && (mode != 2'b00);
    base  = (clr || mrst) ? 0 : m_seq;
    m_evt = 1'b0;
    if (qualifies(mode, m_pin, pin) && pin_is_input_i && base < 2) begin
      if (base == 0) m_cap1 = cnt;
      else           m_cap2 = cnt;
      m_evt = (base == int'(second_sel_i));
      base++;
    end
    m_seq = base;
    m_pin = pin;
    cur_pin = pin;
    if (wr) m_mode = mode;
  endtask

  initial begin
    int done_flag;
    rst_n = 1'b0; pin_sync_i = 0; count_i = '0; edge_mode_i = 0;
    second_sel_i = 0; pin_is_input_i = 0; ctl_wr_i = 0; cap_clr_i = 0;
    m_pin = 0; m_seq = 0; m_cap1 = '0; m_cap2 = '0; m_evt = 0; m_mode = 0; cur_pin = 0;
    done_flag = 0;
    repeat (3) @(negedge clk);
    check(cap1_o == '0, "R1", "slot1 in reset", cap1_o, '0);
    check(cap2_o == '0, "R1", "slot2 in reset", cap2_o, '0);
    check(cap_evt_o == 1'b0, "R1", "event in reset", W'(cap_evt_o), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cap1_o == '0 && cap2_o == '0, "R1", "slots after release", cap1_o | cap2_o, '0);

    // sweep: direction x count mode x edge selection
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int md = 0; md < 4; md++) begin
          string tg;
          logic [9:0] pat;
          tg  = (d == 1) ? "R2 R4" : "R3";
          pat = 10'b1101001011;
          @(negedge clk);
          pin_is_input_i = d[0];
          second_sel_i   = s[0];
          step(cur_pin, 0, 1, 2'b00, "R7");
          step(cur_pin, 0, 1, 2'(md), "R7");
          step(cur_pin, 1, 0, 2'(md), "R6");
          for (int k = 0; k < 10; k++) step(pat[k], 0, 0, 2'(md), tg);
          step(!cur_pin, 1, 0, 2'(md), "R6");
          step(!cur_pin, 0, 0, 2'(md), "R9");
          step(cur_pin, 0, 0, 2'(md), "R4");
        end
      end
    end

    // active-to-active write does not restart, off-to-active does
    @(negedge clk);
    pin_is_input_i = 1; second_sel_i = 1;
    step(0, 0, 1, 2'b11, "R7");
    step(0, 1, 0, 2'b11, "R6");
    step(1, 0, 0, 2'b11, "R4");
    step(0, 0, 0, 2'b11, "R4");
    step(0, 0, 1, 2'b01, "R7");
    step(1, 0, 0, 2'b01, "R7");
    step(1, 0, 0, 2'b01, "R7");
    step(0, 1, 0, 2'b01, "R9");
    step(0, 0, 1, 2'b00, "R7");
    step(0, 0, 1, 2'b10, "R7");
    step(1, 0, 0, 2'b10, "R2");
    step(0, 0, 0, 2'b10, "R7");
    step(0, 0, 0, 2'b10, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule